// File: doc/BRIEF.md
# Octal Shift Register with Sign Extension

This block is a clocked register, eight bits wide by default, that can hold its value, take a full word from a parallel input bus, or move its contents one place towards bit 0 on each rising clock edge. When moving, the top bit is filled either from one of two serial data lines, picked by a select input, or from its own previous value. The second case duplicates the sign bit, so a two's complement number can be shifted right arithmetically.

A low level on the clear input empties the register at once, with no clock needed, and overrides every clocked mode. The parallel output bus carries the register only while the output enable is low and the register is in serial mode. At all other times the bus is forced to zero and a valid flag is low, which stands in for a bus in high impedance. A separate serial output always shows bit 0, so the low bits can be read out one by one as they are shifted.

Top module: `sxr_shift_reg`

## Requirements
- R1: While `rst_n` is low the register is all zeros, at once and regardless of the clock or any other control; it stays zero until a clock edge after `rst_n` has gone high.
- R2: With `rst_n` high and `reg_en_n` high, a rising clock edge leaves the register unchanged, whatever the other controls are.
- R3: With `reg_en_n` low and `ser_par` low, a rising edge copies `par_in` into the register.
- R4: With `reg_en_n` low, `ser_par` high and `sext_n` high, a rising edge moves bit n+1 into bit n for every n below the top. The top bit takes `ser_in0` when `ser_sel` is 0 and `ser_in1` when `ser_sel` is 1.
- R5: With `reg_en_n` low, `ser_par` high and `sext_n` low, a rising edge shifts the lower bits as in R4 but the top bit keeps its old value. A word with its top bit set then keeps its upper bits at 1 while the shift goes on.
- R6: `par_out_vld` is 1 exactly when `oe_n` is 0 and `ser_par` is 1. While it is 1, `par_out` equals the register. While it is 0, `par_out` is all zeros.
- R7: `oe_n` high has no effect on the register: loads, shifts, sign extension and clearing go on as they would with the outputs enabled.
- R8: `ser_out` always equals register bit 0, including during a parallel load and while the parallel outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register changes on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| reg_en_n | input | 1 | Register enable, active low; high means hold |
| ser_par | input | 1 | 1 = serial (shift) mode, 0 = parallel load |
| sext_n | input | 1 | Sign extension in shift mode, active low |
| ser_sel | input | 1 | Serial source select: 0 = ser_in0, 1 = ser_in1 |
| ser_in0 | input | 1 | Serial data source 0 |
| ser_in1 | input | 1 | Serial data source 1 |
| oe_n | input | 1 | Parallel output enable, active low |
| par_in | input | WIDTH | Parallel load data |
| par_out | output | WIDTH | Register contents when valid, zero otherwise |
| par_out_vld | output | 1 | Parallel output is being driven |
| ser_out | output | 1 | Register bit 0, always driven |

## Verification
On every clock edge the assertions check the next state for hold, load, plain shift and sign-extending shift against the previous inputs. They also check that the register is zero during clear, that the bus is zero whenever it is not valid, and that the serial output matches bit 0 of a valid bus. Only the bench scenarios can show the effects that build up over many cycles. These are that a negative word keeps its upper ones through a run of sign-extending shifts while its low bits leave through the serial output, and that activity with the outputs disabled appears in the register once they are enabled again. The immediate effect of a clear applied between clock edges also needs the bench.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_LOAD  = 2'd1,
      MODE_SHIFT = 2'd2,
      MODE_SEXT  = 2'd3
   } sxr_mode_e;
endpackage

// File: rtl/sxr_ctrl.sv
module sxr_ctrl
   import sxr_pkg::*;
(
   input  logic      reg_en_n,
   input  logic      ser_par,
   input  logic      sext_n,
   input  logic      oe_n,
   output sxr_mode_e mode,
   output logic      out_vld
);
   always_comb begin
      if (reg_en_n)     mode = MODE_HOLD;
      else if (!ser_par) mode = MODE_LOAD;
      else if (!sext_n)  mode = MODE_SEXT;
      else               mode = MODE_SHIFT;
   end

   assign out_vld = ser_par & ~oe_n;
endmodule

// File: rtl/sxr_next.sv
module sxr_next
   import sxr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] load_val,
   input  logic             ser_bit,
   input  sxr_mode_e        mode,
   output logic [WIDTH-1:0] nxt
);
   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic fill;
      if (i == TOP) begin : g_top
         assign fill = (mode == MODE_SEXT) ? cur[TOP] : ser_bit;
      end else begin : g_low
         assign fill = cur[i+1];
      end

      always_comb begin
         unique case (mode)
            MODE_HOLD:  nxt[i] = cur[i];
            MODE_LOAD:  nxt[i] = load_val[i];
            default:    nxt[i] = fill;
         endcase
      end
   end
endmodule

// File: rtl/sxr_shift_reg.sv
module sxr_shift_reg
   import sxr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_en_n,
   input  logic             ser_par,
   input  logic             sext_n,
   input  logic             ser_sel,
   input  logic             ser_in0,
   input  logic             ser_in1,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] par_out,
   output logic             par_out_vld,
   output logic             ser_out
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sxr_shift_reg: WIDTH must be at least 2");
   end

   sxr_mode_e        mode;
   logic             vld;
   logic             ser_bit;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] q_nxt;

   assign ser_bit = ser_sel ? ser_in1 : ser_in0;

   sxr_ctrl u_ctrl (
      .reg_en_n (reg_en_n),
      .ser_par  (ser_par),
      .sext_n   (sext_n),
      .oe_n     (oe_n),
      .mode     (mode),
      .out_vld  (vld)
   );

   sxr_next #(.WIDTH(WIDTH)) u_next (
      .cur      (q),
      .load_val (par_in),
      .ser_bit  (ser_bit),
      .mode     (mode),
      .nxt      (q_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   assign par_out_vld = vld;
   assign par_out     = vld ? q : '0;
   assign ser_out     = q[0];

   AST_CLEAR_ZERO: assert property (@(posedge clk) !rst_n |-> (q == '0)); // R1

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en_n |=> $stable(q)); // R2

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_en_n && !ser_par) |=> (q == $past(par_in))); // R3

   AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_en_n && ser_par && sext_n) |=>
         ((q[TOP-1:0] == $past(q[TOP:1])) &&
          (q[TOP] == ($past(ser_sel) ? $past(ser_in1) : $past(ser_in0))))); // R4

   AST_SEXT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_en_n && ser_par && !sext_n) |=>
         ((q[TOP-1:0] == $past(q[TOP:1])) && (q[TOP] == $past(q[TOP])))); // R5

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !par_out_vld |-> (par_out == '0)); // R6

   AST_SER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      par_out_vld |-> (par_out[0] == ser_out)); // R8
endmodule

// File: tb/sxr_shift_reg_tb.sv
module sxr_shift_reg_tb_top;
   localparam int W = 8;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_en_n = 1'b1, ser_par = 1'b1, sext_n = 1'b1, ser_sel = 1'b0;
   logic         ser_in0 = 1'b0, ser_in1 = 1'b0, oe_n = 1'b1;
   logic [W-1:0] par_in = '0;
   logic [W-1:0] par_out;
   logic         par_out_vld, ser_out;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sxr_shift_reg #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_en_n(reg_en_n), .ser_par(ser_par),
      .sext_n(sext_n), .ser_sel(ser_sel), .ser_in0(ser_in0), .ser_in1(ser_in1),
      .oe_n(oe_n), .par_in(par_in), .par_out(par_out),
      .par_out_vld(par_out_vld), .ser_out(ser_out)
   );

   function automatic logic [W-1:0] ref_next(logic [W-1:0] q, logic en_n, logic sp,
                                             logic se_n, logic sel, logic d0, logic d1,
                                             logic [W-1:0] pin);
      if (en_n)  return q;
      if (!sp)   return pin;
      if (!se_n) return {q[W-1], q[W-1:1]};
      return {(sel ? d1 : d0), q[W-1:1]};
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock with the given controls; model updated, outputs checked after the edge
   task automatic step(string req, logic en_n, logic sp, logic se_n, logic sel,
                       logic d0, logic d1, logic oen, logic [W-1:0] pin);
      reg_en_n = en_n; ser_par = sp; sext_n = se_n; ser_sel = sel;
      ser_in0 = d0; ser_in1 = d1; oe_n = oen; par_in = pin;
      @(posedge clk);
      model = ref_next(model, en_n, sp, se_n, sel, d0, d1, pin);
      @(negedge clk);
      check({req, "/R8 ser_out"}, W'(ser_out), W'(model[0]));
      check({req, "/R6 vld"}, W'(par_out_vld), W'(sp & ~oen));
      if (!(sp & ~oen)) check({req, "/R6 bus zero"}, par_out, '0);
      else              check({req, "/R6 bus value"}, par_out, model);
   endtask

   // enable the bus in hold mode (no state change) and compare the whole register
   task automatic observe(string req);
      reg_en_n = 1'b1; ser_par = 1'b1; oe_n = 1'b0;
      #1;
      check({req, " register"}, par_out, model);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4242));
      repeat (2) @(negedge clk);
      oe_n = 1'b0; #1;
      check("R1 reset state", par_out, '0);
      check("R8 reset ser_out", W'(ser_out), '0);
      rst_n = 1'b1;

      // R3 load with outputs disabled by ser_par low
      step("R3 load", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96);
      observe("R3 after load");
      // R2 hold with noisy controls
      step("R2 hold", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A);
      observe("R2 hold");
      // R4 shifts drawing from each serial source
      step("R4 shift d0", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      step("R4 shift d1", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      step("R4 shift d1 zero", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      observe("R4 after shifts");
      // R5 negative word stays negative
      step("R5 load neg", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h85);
      for (int k = 0; k < 4; k++)
         step("R5 sext", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      observe("R5 sign kept");
      check("R5 upper ones", {par_out[W-1:W-5], 3'b000}, 8'hF8);
      // R7 activity with bus disabled
      step("R7 load hidden", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
      step("R7 shift hidden", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
      step("R7 sext hidden", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
      observe("R7 state advanced");
      // R1 clear between edges, bus disabled
      oe_n = 1'b1; rst_n = 1'b0; model = '0; #1;
      check("R1 async clear ser_out", W'(ser_out), '0);
      oe_n = 1'b0; #1;
      check("R1/R7 async clear", par_out, '0);
      @(negedge clk); rst_n = 1'b1;

      for (int n = 0; n < 400; n++) begin
         logic [3:0] r = 4'($urandom);
         step("RAND R2-R8", r[0] & r[1], ~(r[2] & r[3] & r[0]), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
         if (n % 16 == 15) observe("RAND R4 R5");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule